// File: doc/BRIEF.md
# Bit-Serial Fuzzy Maximum/Minimum Selector

This block takes two fuzzy membership grades as two serial bit streams, most significant bit first, and compares them. It passes on the bit stream of the larger operand in maximum mode, or of the smaller operand in minimum mode, as the bits come in. A three-state decision machine records one of three conditions: the operands are still equal, A has turned out larger, or A has turned out smaller. Once a decision is made it is held until the next comparison is started. Because the grades are unsigned binary codes, comparing the magnitudes is the same as comparing the membership values.

A synchronous `start` pulse begins each comparison. It clears the decision, loads the bit counter and samples the mode. After that, one bit pair is taken in each cycle in which `bit_valid` is high. The selected bit appears on `out_bit` in the same cycle, so the bit that settles the comparison already carries the new decision. A length counter raises `done` for one cycle after `N` bit pairs have been taken, so one comparison of N-bit operands takes at least N+1 cycles. The asynchronous reset `rst_n` is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `fuzzy_serial_select`

## Requirements
- R1: After `rst_n` is asserted, `out_bit` and `done` are 0, the machine is in the equal state and the mode is minimum (0).
- R2: A cycle with `start`=1 returns the machine to the equal state, clears the bit count and samples `mode_max` (1 = maximum, 0 = minimum).
- R3: In the equal state, a bit pair with `a_bit`=`b_bit` keeps the equal state, and `out_bit` equals `b_bit` in that cycle.
- R4: In the equal state, the first pair with A=1,B=0 moves the machine to A-larger, and the first pair with A=0,B=1 moves it to A-smaller. `out_bit` for that same pair already follows the new decision.
- R5: In maximum mode, `out_bit` follows `a_bit` when A is larger and `b_bit` when A is smaller, so the collected output word equals the larger operand.
- R6: In minimum mode, `out_bit` follows `b_bit` when A is larger and `a_bit` when A is smaller, so the collected output word equals the smaller operand.
- R7: The A-larger and A-smaller decisions are left only through `start`. Later bit pairs of any value do not change them.
- R8: Changes on `mode_max` outside a `start` cycle have no effect on the operation in progress.
- R9: `done` is high for exactly the one cycle after the N-th bit pair taken since `start`. It does not rise again for further pairs until the next `start`.
- R10: When `start` and `bit_valid` are high in the same cycle, the bit pair is ignored: `out_bit` is 0, and the pair neither moves the decision nor counts toward N.
- R11: In a cycle with `bit_valid`=0, `out_bit` is 0, and the decision and the count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Synchronous start of a new comparison |
| mode_max | input | 1 | 1 selects maximum, 0 selects minimum; sampled on `start` |
| bit_valid | input | 1 | A bit pair is present on `a_bit`/`b_bit` |
| a_bit | input | 1 | Serial operand A, most significant bit first |
| b_bit | input | 1 | Serial operand B, most significant bit first |
| out_bit | output | 1 | Serial bit of the selected operand, valid in the cycle its pair is taken |
| done | output | 1 | One-cycle pulse after N bit pairs have been taken |

## Verification
Two functions can fall in the same cycle: a `start` and the taking of a bit pair, and the decision on a bit and the output of that same bit. The bench raises `start` together with `bit_valid` and deliberately unequal bits. It then expects `out_bit` to be 0 and the following operation to behave as if that pair never came, which would not be so if the pair had left a stale decision or an extra count. The bench also places the deciding bit pair at the most significant and at the least significant position. A behavioural reference model checks, on every cycle, that the output of that deciding bit already follows the new decision rather than the registered one.

// File: rtl/fz_sel_pkg.sv
package fz_sel_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_AGT = 2'd1,
    CMP_ALT = 2'd2
  } cmp_state_e;
endpackage

// File: rtl/fz_cmp_fsm.sv
module fz_cmp_fsm
  import fz_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       take,
  input  logic       a_bit,
  input  logic       b_bit,
  output cmp_state_e state_q,
  output cmp_state_e decision
);
  cmp_state_e state_d;

  // decision: state including the bit pair presented this cycle
  always_comb begin
    decision = state_q;
    if (state_q == CMP_EQ && a_bit != b_bit) begin
      decision = a_bit ? CMP_AGT : CMP_ALT;
    end
  end

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = CMP_EQ;
    end else if (take) begin
      state_d = decision;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CMP_EQ;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/fz_len_counter.sv
module fz_len_counter #(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic take,
  output logic done
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (take && cnt_q != FULL);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
    done_d = take && !start && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end
endmodule

// File: rtl/fz_out_mux.sv
module fz_out_mux
  import fz_sel_pkg::*;
(
  input  logic       take,
  input  logic       mode_max,
  input  cmp_state_e decision,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       out_bit
);
  logic pick_a;

  always_comb begin
    unique case (decision)
      CMP_AGT: pick_a = mode_max;
      CMP_ALT: pick_a = !mode_max;
      default: pick_a = 1'b0;
    endcase
    out_bit = take && (pick_a ? a_bit : b_bit);
  end
endmodule

// File: rtl/fuzzy_serial_select.sv
module fuzzy_serial_select
  import fz_sel_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_max,
  input  logic bit_valid,
  input  logic a_bit,
  input  logic b_bit,
  output logic out_bit,
  output logic done
);
  logic       take;
  logic       mode_q;
  cmp_state_e state_q;
  cmp_state_e decision;

  assign take = bit_valid && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (start) begin
      mode_q <= mode_max;
    end
  end

  fz_cmp_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .take     (take),
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .state_q  (state_q),
    .decision (decision)
  );

  fz_len_counter #(.N(N)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .take  (take),
    .done  (done)
  );

  fz_out_mux u_mux (
    .take     (take),
    .mode_max (mode_q),
    .decision (decision),
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .out_bit  (out_bit)
  );
endmodule

// File: rtl/fz_select_checker.sv
module fz_select_checker
  import fz_sel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bit_valid,
  input logic       a_bit,
  input logic       b_bit,
  input logic       out_bit,
  input logic       done,
  input cmp_state_e state_q
);
  AST_START_TO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state_q == CMP_EQ); // R2

  AST_EQ_FOLLOWS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !start && state_q == CMP_EQ && a_bit == b_bit) |-> out_bit == b_bit); // R3

  AST_DECIDE_AGT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !start && state_q == CMP_EQ && a_bit && !b_bit) |=> state_q == CMP_AGT); // R4

  AST_DECIDE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !start && state_q == CMP_EQ && !a_bit && b_bit) |=> state_q == CMP_ALT); // R4

  AST_DECISION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CMP_EQ && !start) |=> $stable(state_q)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R10

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && !start) |-> !out_bit); // R11
endmodule

bind fuzzy_serial_select fz_select_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .bit_valid (bit_valid),
  .a_bit     (a_bit),
  .b_bit     (b_bit),
  .out_bit   (out_bit),
  .done      (done),
  .state_q   (state_q)
);

// File: tb/fuzzy_serial_select_bench.sv
module fuzzy_serial_select_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, start, mode_max, bit_valid, a_bit, b_bit;
  logic out_bit, done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // reference model: 0 equal, 1 A larger, 2 A smaller
  int ref_st, ref_md, ref_cnt;
  bit ref_dn;

  always #5 clk = ~clk;

  fuzzy_serial_select #(.N(N)) u_fuzzy_serial_select (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_max(mode_max),
    .bit_valid(bit_valid), .a_bit(a_bit), .b_bit(b_bit),
    .out_bit(out_bit), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit model_out(bit s, bit v, bit a, bit b);
    int ns;
    if (s || !v) return 1'b0;
    ns = (ref_st == 0 && a != b) ? (a ? 1 : 2) : ref_st;
    if (ns == 0) return b;
    if (ns == 1) return ref_md ? a : b;
    return ref_md ? b : a;
  endfunction

  task automatic step(input bit s, input bit m, input bit v, input bit a,
                      input bit b, input string tag, output bit got);
    bit e;
    @(negedge clk);
    start = s; mode_max = m; bit_valid = v; a_bit = a; b_bit = b;
    #1;
    e = model_out(s, v, a, b);
    check(out_bit === e, tag, "out_bit", int'(out_bit), int'(e));
    check(done === ref_dn, "R9", "done", int'(done), int'(ref_dn));
    got = out_bit;
    @(posedge clk);
    if (s) begin
      ref_st = 0; ref_md = m; ref_cnt = 0; ref_dn = 1'b0;
    end else begin
      ref_dn = 1'b0;
      if (v) begin
        if (ref_st == 0 && a != b) ref_st = a ? 1 : 2;
        if (ref_cnt < N) begin
          ref_cnt++;
          if (ref_cnt == N) ref_dn = 1'b1;
        end
      end
    end
  endtask

  // one full comparison; gap inserts idle cycles, flip toggles mode input mid-op
  task automatic run_op(input bit m, input logic [N-1:0] a, input logic [N-1:0] b,
                        input bit gap, input bit flip, input string tag);
    logic [N-1:0] word;
    logic [N-1:0] exp;
    bit g;
    step(1'b1, m, 1'b0, 1'b0, 1'b0, "R2", g);
    for (int i = N - 1; i >= 0; i--) begin
      step(1'b0, flip ? ~m : m, 1'b1, a[i], b[i], tag, g);
      word[i] = g;
      if (gap) step(1'b0, flip ? ~m : m, 1'b0, 1'b1, 1'b0, "R11", g);
    end
    exp = m ? ((a > b) ? a : b) : ((a < b) ? a : b);
    check(word === exp, tag, "word", int'(word), int'(exp));
    step(1'b0, m, 1'b0, 1'b0, 1'b0, "R9", g);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit g;
    rst_n = 1'b0; start = 1'b0; mode_max = 1'b0; bit_valid = 1'b0;
    a_bit = 1'b0; b_bit = 1'b0;
    ref_st = 0; ref_md = 0; ref_cnt = 0; ref_dn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_bit === 1'b0, "R1", "out_bit in reset", int'(out_bit), 0);
    check(done === 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    // R1: equal state and minimum mode right after reset
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1", g);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R1", g);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1", g);

    run_op(1'b1, 8'hA5, 8'h3C, 1'b0, 1'b0, "R5");
    run_op(1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0, "R6");
    run_op(1'b1, 8'h3C, 8'hA5, 1'b0, 1'b0, "R5");
    run_op(1'b0, 8'h3C, 8'hA5, 1'b0, 1'b0, "R6");
    run_op(1'b1, 8'h5A, 8'h5A, 1'b0, 1'b0, "R3");
    run_op(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R3");
    run_op(1'b1, 8'h12, 8'h13, 1'b0, 1'b0, "R4");
    run_op(1'b0, 8'h13, 8'h12, 1'b0, 1'b0, "R4");
    run_op(1'b1, 8'h80, 8'h7F, 1'b0, 1'b0, "R7");
    run_op(1'b0, 8'h7F, 8'h80, 1'b0, 1'b0, "R7");
    run_op(1'b1, 8'h6E, 8'h6A, 1'b1, 1'b0, "R11");
    run_op(1'b1, 8'hC3, 8'h4D, 1'b0, 1'b1, "R8");
    run_op(1'b0, 8'hC3, 8'h4D, 1'b0, 1'b1, "R8");

    // R10: start with a valid, unequal pair must not decide or count
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10", g);
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R10", g);
    // R9: extra pairs after N give no second done
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9", g);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10", g);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2", g);

    for (int k = 0; k < 40; k++) begin
      logic [N-1:0] ra, rb;
      bit rm;
      ra = N'($urandom); rb = N'($urandom); rm = 1'($urandom);
      if (k % 5 == 0) rb = ra ^ N'(1 << (k % N));
      run_op(rm, ra, rb, 1'(k % 3 == 0), 1'(k % 4 == 1), rm ? "R5" : "R6");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule